// File: doc/BRIEF.md
# Serial Control Word Decoder for a Frequency Synthesizer

The block is the listening side of a three-wire serial link into a direct digital synthesizer. A controller holds the active-low frame strobe `fsync_n` low and shifts a 16-bit word onto `sdata`, most significant bit first. Each bit is taken on a falling edge of `sclk`. The block decodes each finished word as a control word, a frequency register write or a phase register write. Its outputs are the two frequency tuning words, the two phase offsets and the control bits that drive the oscillator core.

Frequency words can be loaded in two ways. In paired mode, two writes to the same register supply the low 14 bits and then the high 14 bits, and the full 28-bit value changes only after the second write. In split mode, each write replaces one half only, and a half-select bit in the control word names that half. The core-clear control bit is brought out as `acc_clear`, which holds the phase accumulator at zero. Setting it leaves every stored register intact. `sclk`, `sdata` and `fsync_n` are treated as slow signals sampled by the block clock `clk`. Each serial level must be held for at least two `clk` cycles.

Top module: `dds_serial_decoder`

## Requirements
- R1: After reset, both frequency words, both phase words and the outputs `fsel`, `psel`, `sleep`, `acc_clear` and `sign_out` are all zero. The internal mode is split mode with the low half selected, and no paired write is pending.
- R2: While `fsync_n` is low, each falling edge of `sclk` shifts in one bit of `sdata`, most significant bit first. The word is decoded at the 16th edge. Further edges before `fsync_n` rises have no effect.
- R3: If `fsync_n` rises before 16 bits have been taken, the partial word is discarded and no output changes. The next frame starts counting again from its first bit.
- R4: A word whose bits 15:14 are 00 is a control word. Its fields are: bit 13 paired mode (1) or split mode (0), bit 12 half select (1 = high half), bit 11 `fsel`, bit 10 `psel`, bit 8 `acc_clear`, bit 7 `sleep`, bit 5 `sign_out`. Bits 9, 6 and 4:0 are ignored.
- R5: In split mode, a word whose bits 15:14 are 01 writes frequency register 0 and one whose bits 15:14 are 10 writes frequency register 1. Bits 13:0 replace the half named by the half-select bit, and the other half is kept.
- R6: In paired mode, the first write to a frequency register stores bits 13:0 as a pending low half and leaves the outputs unchanged. The next write to the same register sets the register to {second data, first data} and clears the pending state.
- R7: In paired mode, if a write to the other frequency register arrives while a low half is pending, it starts a new pair for that register. Any control word discards a pending low half.
- R8: A word whose bits 15:14 are 11 is a phase write. Bit 13 selects phase register 1 (1) or phase register 0 (0), and bits 11:0 become its value.
- R9: While `acc_clear` is 1, register writes still take effect. Setting `acc_clear` and clearing it again leaves all frequency and phase words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, idles high; bits are taken on its falling edges |
| sdata | input | 1 | Serial data, most significant bit first |
| fsync_n | input | 1 | Active-low frame strobe |
| freq0 | output | FREQ_W (28) | Frequency tuning word 0 |
| freq1 | output | FREQ_W (28) | Frequency tuning word 1 |
| phase0 | output | PHASE_W (12) | Phase offset 0 |
| phase1 | output | PHASE_W (12) | Phase offset 1 |
| fsel | output | 1 | Selects frequency word 1 when high |
| psel | output | 1 | Selects phase word 1 when high |
| sleep | output | 1 | Requests the core to stop |
| acc_clear | output | 1 | Holds the phase accumulator at zero |
| sign_out | output | 1 | Enables the sign-bit output of the core |

## Verification
A bit counter that is off by one shifts every decoded field by one position. This shows on the outputs on the first completed word after the fault. A pending-half flag that is left set or cleared in error changes the result of the second write in a pair. That makes a stale high or low half visible on `freq0` or `freq1` within two frames. A failure to discard an aborted frame corrupts the word decoded in the next frame, so the frequency or control outputs differ immediately after that frame ends.

// File: rtl/dds_serial_decoder.sv
module dds_serial_decoder #(
  parameter int FREQ_W  = 28,
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sdata,
  input  logic               fsync_n,
  output logic [FREQ_W-1:0]  freq0,
  output logic [FREQ_W-1:0]  freq1,
  output logic [PHASE_W-1:0] phase0,
  output logic [PHASE_W-1:0] phase1,
  output logic               fsel,
  output logic               psel,
  output logic               sleep,
  output logic               acc_clear,
  output logic               sign_out
);
  localparam int WORD_W = 16;
  localparam int HALF   = FREQ_W / 2;
  localparam int CW     = $clog2(WORD_W + 1);

  logic              sclk_q;
  logic [WORD_W-2:0] shreg;
  logic [CW-1:0]     cnt;
  logic [FREQ_W-1:0] freq_r [2];
  logic [HALF-1:0]   stage;
  logic              pend, pend_reg, paired, half_hi;

  wire              fall  = sclk_q & ~sclk & ~fsync_n & (cnt != CW'(WORD_W));
  wire              last  = fall & (cnt == CW'(WORD_W - 1));
  wire [WORD_W-1:0] word  = {shreg, sdata};
  wire [1:0]        wtype = word[15:14];
  wire [HALF-1:0]   data  = word[HALF-1:0];
  wire              wsel  = wtype[1];

  assign freq0 = freq_r[0];
  assign freq1 = freq_r[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      shreg  <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk;
      if (fsync_n) begin
        cnt <= '0;
      end else if (fall) begin
        cnt   <= cnt + 1'b1;
        shreg <= {shreg[WORD_W-3:0], sdata};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_r[0] <= '0;
      freq_r[1] <= '0;
      phase0    <= '0;
      phase1    <= '0;
      stage     <= '0;
      pend      <= 1'b0;
      pend_reg  <= 1'b0;
      paired    <= 1'b0;
      half_hi   <= 1'b0;
      fsel      <= 1'b0;
      psel      <= 1'b0;
      sleep     <= 1'b0;
      acc_clear <= 1'b0;
      sign_out  <= 1'b0;
    end else if (last) begin
      case (wtype)
        2'b00: begin
          paired    <= word[13];
          half_hi   <= word[12];
          fsel      <= word[11];
          psel      <= word[10];
          acc_clear <= word[8];
          sleep     <= word[7];
          sign_out  <= word[5];
          pend      <= 1'b0;
        end
        2'b11: begin
          if (word[13]) phase1 <= word[PHASE_W-1:0];
          else          phase0 <= word[PHASE_W-1:0];
        end
        default: begin
          if (paired) begin
            if (pend && pend_reg == wsel) begin
              freq_r[wsel] <= {data, stage};
              pend         <= 1'b0;
            end else begin
              stage    <= data;
              pend     <= 1'b1;
              pend_reg <= wsel;
            end
          end else begin
            if (half_hi) freq_r[wsel][FREQ_W-1:HALF] <= data;
            else         freq_r[wsel][HALF-1:0]      <= data;
            pend <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

module dds_serial_decoder_chk #(
  parameter int FREQ_W  = 28,
  parameter int PHASE_W = 12,
  parameter int CW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sclk,
  input logic               sclk_q,
  input logic               fsync_n,
  input logic [CW-1:0]      cnt,
  input logic               pend,
  input logic               paired,
  input logic [FREQ_W-1:0]  freq0,
  input logic [FREQ_W-1:0]  freq1,
  input logic [PHASE_W-1:0] phase0,
  input logic [PHASE_W-1:0] phase1,
  input logic [4:0]         ctrl
);
  wire edge_in = sclk_q & ~sclk & ~fsync_n;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(16));

  assert_abort_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_n |=> cnt == '0);

  assert_freq_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({freq0, freq1}) |-> ($past(cnt) == CW'(15) && $past(edge_in)));

  assert_ctrl_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl) |-> ($past(cnt) == CW'(15) && $past(edge_in)));

  assert_phase_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({phase0, phase1}) |-> ($past(cnt) == CW'(15) && $past(edge_in)));

  assert_pend_paired_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> paired);
endmodule

bind dds_serial_decoder dds_serial_decoder_chk #(
  .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sclk_q(sclk_q), .fsync_n(fsync_n),
  .cnt(cnt), .pend(pend), .paired(paired),
  .freq0(freq0), .freq1(freq1), .phase0(phase0), .phase1(phase1),
  .ctrl({fsel, psel, sleep, acc_clear, sign_out})
);

// File: tb/test_dds_serial_decoder.sv
module test_dds_serial_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic sdata = 1'b0;
  logic fsync_n = 1'b1;
  logic [27:0] freq0, freq1;
  logic [11:0] phase0, phase1;
  logic fsel, psel, sleep, acc_clear, sign_out;

  int checks = 0;
  int errors = 0;

  logic [27:0] m_freq [2];
  logic [11:0] m_phase [2];
  logic m_fsel, m_psel, m_sleep, m_clr, m_sign, m_paired, m_hi, m_pend, m_preg;
  logic [13:0] m_stage;

  always #2.5 clk = ~clk;

  dds_serial_decoder i_dds_serial_decoder (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .fsync_n(fsync_n),
    .freq0(freq0), .freq1(freq1), .phase0(phase0), .phase1(phase1),
    .fsel(fsel), .psel(psel), .sleep(sleep), .acc_clear(acc_clear), .sign_out(sign_out)
  );

  task automatic chk(input string req, input string what, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "freq0", freq0, m_freq[0]);
    chk(req, "freq1", freq1, m_freq[1]);
    chk(req, "phase0", 28'(phase0), 28'(m_phase[0]));
    chk(req, "phase1", 28'(phase1), 28'(m_phase[1]));
    chk(req, "ctrl", 28'({fsel, psel, sleep, acc_clear, sign_out}),
        28'({m_fsel, m_psel, m_sleep, m_clr, m_sign}));
  endtask

  task automatic model(input logic [15:0] w);
    case (w[15:14])
      2'b00: begin
        m_paired = w[13]; m_hi = w[12]; m_fsel = w[11]; m_psel = w[10];
        m_clr = w[8]; m_sleep = w[7]; m_sign = w[5]; m_pend = 1'b0;
      end
      2'b11: m_phase[w[13]] = w[11:0];
      default: begin
        if (m_paired) begin
          if (m_pend && m_preg == w[15]) begin
            m_freq[w[15]] = {w[13:0], m_stage};
            m_pend = 1'b0;
          end else begin
            m_stage = w[13:0]; m_pend = 1'b1; m_preg = w[15];
          end
        end else begin
          if (m_hi) m_freq[w[15]][27:14] = w[13:0];
          else      m_freq[w[15]][13:0]  = w[13:0];
          m_pend = 1'b0;
        end
      end
    endcase
  endtask

  task automatic send(input logic [15:0] w, input int nb);
    @(negedge clk);
    fsync_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdata = (i < 16) ? w[15-i] : i[0];
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    fsync_n = 1'b1;
    repeat (3) @(negedge clk);
    if (nb >= 16) model(w);
  endtask

  function automatic logic [15:0] ctrl_word(input logic pr, input logic hi, input logic fs,
      input logic ps, input logic cl, input logic sl, input logic sg);
    return {2'b00, pr, hi, fs, ps, 1'b0, cl, sl, 1'b0, sg, 5'b0};
  endfunction

  initial begin
    #900us;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_freq[0] = '0; m_freq[1] = '0; m_phase[0] = '0; m_phase[1] = '0;
    m_fsel = 0; m_psel = 0; m_sleep = 0; m_clr = 0; m_sign = 0;
    m_paired = 0; m_hi = 0; m_pend = 0; m_preg = 0; m_stage = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1");

    // R4: every combination of the five output control bits, ignored bits toggled
    for (int k = 0; k < 32; k++) begin
      logic [15:0] w;
      w = ctrl_word(1'b0, 1'b0, k[4], k[3], k[2], k[1], k[0]);
      w[9] = k[0]; w[6] = k[1]; w[4:0] = 5'(k * 7);
      send(w, 16);
      check_all("R4");
    end

    // R5: split-mode half writes to both registers
    for (int k = 0; k < 16; k++) begin
      logic [13:0] d;
      d = 14'((k * 1237 + 5) & 14'h3fff);
      send(ctrl_word(1'b0, k[1], 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 16);
      send({k[0] ? 2'b10 : 2'b01, d}, 16);
      check_all("R5");
    end

    // R6: paired writes, no update after the first half
    send(ctrl_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 16);
    for (int k = 0; k < 8; k++) begin
      logic [13:0] lo, hi;
      lo = 14'((k * 3001 + 11) & 14'h3fff);
      hi = 14'((k * 977 + 300) & 14'h3fff);
      send({k[0] ? 2'b10 : 2'b01, lo}, 16);
      check_all("R6");
      send({k[0] ? 2'b10 : 2'b01, hi}, 16);
      check_all("R6");
      chk("R6", "pair value", k[0] ? freq1 : freq0, {hi, lo});
    end

    // R7: pair interrupted by the other register, then by a control word
    send({2'b01, 14'h1111}, 16);
    send({2'b10, 14'h2222}, 16);
    send({2'b10, 14'h3333}, 16);
    check_all("R7");
    chk("R7", "freq1 restart", freq1, {14'h3333, 14'h2222});
    send({2'b01, 14'h0aaa}, 16);
    send(ctrl_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 16);
    send({2'b01, 14'h0bbb}, 16);
    check_all("R7");
    send({2'b01, 14'h0ccc}, 16);
    check_all("R7");
    chk("R7", "freq0 after ctrl", freq0, {14'h0ccc, 14'h0bbb});

    // R8: phase writes with select bit, bit 12 set to show it is not stored
    for (int k = 0; k < 8; k++) begin
      logic [11:0] p;
      p = 12'((k * 523 + 9) & 12'hfff);
      send({2'b11, k[0], 1'b1, p}, 16);
      check_all("R8");
    end

    // R3: aborted frames are dropped and the next frame counts from zero
    send(ctrl_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 16);
    for (int n = 1; n < 16; n += 3) begin
      send({2'b01, 14'h3fff}, n);
      check_all("R3");
    end
    send({2'b10, 14'h0123}, 16);
    check_all("R3");

    // R2: extra falling edges after the 16th are ignored
    send({2'b01, 14'h2468}, 21);
    check_all("R2");
    send(ctrl_word(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0), 19);
    check_all("R2");

    // R9: accumulator clear keeps contents and writes still land
    send(ctrl_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0), 16);
    check_all("R9");
    send({2'b10, 14'h1357}, 16);
    send({2'b11, 1'b0, 1'b0, 12'h5a5}, 16);
    check_all("R9");
    send(ctrl_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 16);
    check_all("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule